// File: doc/BRIEF.md
# Tick-Scanned Sixteen-Channel Periodic Timer Table

The block keeps sixteen periodic timers in a small table memory instead of sixteen separate counters. Each table slot holds a programmed period word and a running count word. A single pulse on the tick input starts a scan. The scan visits the slots in ascending order, one slot per clock, and uses one shared decrementer. An enabled slot whose count has reached its last tick reloads from the period word and raises its bit in the event register.

Timers are set up through a one-word command port. A small register interface gives access to the event register (write-one-to-clear), the interrupt mask, a count of completed scans and a control word. The control word holds the global interrupt enable, the tick engine enable and a count of ticks that were lost because a scan was still running. The tick-rate prescaler and the host bus protocol are outside the block.

Top module: `tick_timer_table`

## Requirements
- R1: A command word on `cmd_word_i` with `cmd_valid_i` high configures one timer. Bit 31 is the enable, bit 30 selects restart mode (1) or one-shot mode (0), bits 19:16 give the timer index 0..15, and bits 15:0 give the period. Bits 29:20 are ignored. The period is written into both the period word and the count word of the slot.
- R2: On each scan an enabled timer's count drops by one. A timer with period P raises bit i of the event register (timer i) on every P-th accepted tick and reloads its count from the period word. A period field of 0 means 65536 ticks.
- R3: A timer in one-shot mode disables itself when it expires for the first time and raises no further events.
- R4: An accepted tick starts a scan of 16 clocks. The scan counter (register 2) goes up by one only when the scan ends, whether or not any timer is enabled. A tick is accepted only when the engine enable (register 3 bit 1) is set.
- R5: A tick that arrives while a scan is running starts no new scan. It adds one to the overrun counter in register 3 bits 15:8.
- R6: A command that arrives during a scan is held and applied only after the scan completes.
- R7: The event register (address 0) is read/write-one-to-clear. Writing 1 clears a bit, writing 0 leaves it unchanged, and several bits can be cleared in one write.
- R8: If a timer sets an event bit in the same cycle that software clears it, the bit ends up set.
- R9: The mask register (address 1) can be read and written.
- R10: `irq_o` is high exactly when the global interrupt enable (register 3 bit 0) is set and at least one event bit is set whose mask bit is also set.
- R11: After reset all registers read zero, all timers are disabled and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle tick pulse that starts a table scan |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 32 | Timer configure command |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 event, 1 mask, 2 scan count, 3 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a software clear that lands on the exact clock edge where the scanner expires the same timer. The bench sets timer 0 to period 1 so that it expires on the first scan slot. It then drives the clear write in the cycle right after the tick pulse, so both requests meet on one edge. A second hard case is a command that arrives mid-scan for a slot the scan has not reached yet. The bench issues the command one cycle after the tick, before slot 2 is visited. It then checks that the old count was used for that scan and that the new period takes effect only on the next tick.

// File: rtl/tick_timer_table.sv
module tick_timer_table #(
  parameter int NT    = 16,
  parameter int CNT_W = 16,
  parameter int OVR_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        cmd_valid_i,
  input  logic [31:0] cmd_word_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int IW = $clog2(NT);
  localparam logic [IW-1:0] LAST = IW'(NT - 1);

  logic [CNT_W-1:0] per_q [NT];
  logic [CNT_W-1:0] cur_q [NT];
  logic [NT-1:0]    en_q, rs_q, ev_q, mask_q, ev_set, clr;
  logic             busy_q, gie_q, eng_q;
  logic [IW-1:0]    idx_q;
  logic [15:0]      scan_cnt_q;
  logic [OVR_W-1:0] ovr_q;

  logic             pend_q, pend_en_q, pend_rs_q;
  logic [IW-1:0]    pend_idx_q;
  logic [CNT_W-1:0] pend_per_q;
  logic             apply, start, hit;
  logic [CNT_W-1:0] cur_rd;
  logic             unused_bits;

  assign unused_bits = ^cmd_word_i[29:20];
  assign apply  = pend_q && !busy_q;
  assign start  = tick_i && eng_q && !busy_q;
  assign cur_rd = cur_q[idx_q];
  assign hit    = busy_q && en_q[idx_q] && (cur_rd == CNT_W'(1));
  assign ev_set = hit ? (NT'(1) << idx_q) : '0;
  assign clr    = (reg_wr_i && reg_addr_i == 2'd0) ? reg_wdata_i[NT-1:0] : '0;
  assign irq_o  = gie_q && |(ev_q & mask_q);

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = 16'(ev_q);
      2'd1:    reg_rdata_o = 16'(mask_q);
      2'd2:    reg_rdata_o = scan_cnt_q;
      default: reg_rdata_o = {ovr_q, 6'b0, eng_q, gie_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_en_q  <= 1'b0;
      pend_rs_q  <= 1'b0;
      pend_idx_q <= '0;
      pend_per_q <= '0;
    end else if (cmd_valid_i) begin
      pend_q     <= 1'b1;
      pend_en_q  <= cmd_word_i[31];
      pend_rs_q  <= cmd_word_i[30];
      pend_idx_q <= cmd_word_i[16 +: IW];
      pend_per_q <= cmd_word_i[CNT_W-1:0];
    end else if (apply) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (apply) begin
      per_q[pend_idx_q] <= pend_per_q;
      cur_q[pend_idx_q] <= pend_per_q;
    end else if (busy_q && en_q[idx_q]) begin
      cur_q[idx_q] <= hit ? per_q[idx_q] : cur_rd - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      rs_q <= '0;
    end else if (apply) begin
      en_q[pend_idx_q] <= pend_en_q;
      rs_q[pend_idx_q] <= pend_rs_q;
    end else if (hit && !rs_q[idx_q]) begin
      en_q[idx_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      idx_q      <= '0;
      scan_cnt_q <= '0;
      ovr_q      <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q     <= 1'b0;
          scan_cnt_q <= scan_cnt_q + 16'd1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (busy_q && tick_i && eng_q) ovr_q <= ovr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
      eng_q  <= 1'b0;
    end else begin
      ev_q <= (ev_q & ~clr) | ev_set;
      if (reg_wr_i && reg_addr_i == 2'd1) mask_q <= reg_wdata_i[NT-1:0];
      if (reg_wr_i && reg_addr_i == 2'd3) begin
        gie_q <= reg_wdata_i[0];
        eng_q <= reg_wdata_i[1];
      end
    end
  end

  p_oneshot_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !rs_q[idx_q] && !apply) |=> !en_q[$past(idx_q)]);

  p_scan_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST) |=> !busy_q);

  p_count_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scan_cnt_q) |-> $fell(busy_q));

  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && eng_q && idx_q != LAST) |=> (busy_q && ovr_q == $past(ovr_q) + 1'b1));

  p_cmd_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_q && idx_q != LAST) |=> (pend_q && busy_q));

  p_evt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 2'd0) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_set != '0) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_q || mask_q == '0) |-> !irq_o);
endmodule

// File: tb/tick_timer_table_tb.sv
`timescale 1ns/1ps
module tick_timer_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tick_timer_table dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_valid_i(cmd_valid),
    .cmd_word_i(cmd_word), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] mk(bit en, bit rs, int idx, int per);
    return {en, rs, 10'b0, 4'(idx), 16'(per)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (20) @(negedge clk);
    end
  endtask

  task automatic all_off();
    for (int t = 0; t < 16; t++) cmd(mk(0, 0, t, 1));
    wr(2'd0, 16'hFFFF);
  endtask

  localparam int NV = 6;
  localparam logic [31:0] V_CMD [NV] = '{
    32'hC000_0001, 32'hC005_0003, 32'hC005_0003,
    32'h800F_0002, 32'hFFF7_0004, 32'h4003_0002};
  localparam int          V_NT  [NV] = '{1, 2, 3, 5, 4, 4};
  localparam logic [15:0] V_EXP [NV] = '{
    16'h0001, 16'h0000, 16'h0020, 16'h8000, 16'h0080, 16'h0000};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check($sformatf("R11 reset reg %0d", a), v, 0);
    end
    check("R11 reset irq", irq, 0);

    ticks(1);
    rd(2'd2, v);
    check("R4 no count with engine off", v, 0);
    wr(2'd3, 16'h0002);

    for (int i = 0; i < NV; i++) begin
      all_off();
      cmd(V_CMD[i]);
      ticks(V_NT[i]);
      rd(2'd0, v);
      check($sformatf("R1 R2 R3 vector %0d", i), v, V_EXP[i]);
    end

    all_off();
    cmd(mk(1, 0, 15, 2));
    ticks(2);
    rd(2'd0, v);
    check("R3 one-shot first expiry", v, 16'h8000);
    wr(2'd0, 16'h8000);
    ticks(4);
    rd(2'd0, v);
    check("R3 one-shot no repeat", v, 0);

    all_off();
    cmd(mk(1, 1, 9, 0));
    ticks(3);
    rd(2'd0, v);
    check("R2 period zero is long", v, 0);

    all_off();
    rd(2'd2, sc);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check("R4 count unchanged mid-scan", v, sc);
    repeat (14) @(negedge clk);
    rd(2'd2, v);
    check("R4 count after scan, no timers", v, sc + 16'd1);

    rd(2'd2, sc);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (24) @(negedge clk);
    rd(2'd3, v);
    check("R5 overrun counted", v[15:8], 1);
    rd(2'd2, v);
    check("R5 single scan", v, sc + 16'd1);

    all_off();
    cmd(mk(1, 1, 0, 1));
    cmd(mk(1, 1, 5, 1));
    ticks(1);
    rd(2'd0, v);
    check("R7 two events set", v, 16'h0021);
    wr(2'd0, 16'h0000);
    rd(2'd0, v);
    check("R7 write zero no effect", v, 16'h0021);
    wr(2'd0, 16'h0001);
    rd(2'd0, v);
    check("R7 clear one bit", v, 16'h0020);
    cmd(mk(1, 1, 3, 1));
    ticks(1);
    wr(2'd0, 16'h0029);
    rd(2'd0, v);
    check("R7 clear several bits", v, 16'h0000);

    all_off();
    cmd(mk(1, 1, 0, 1));
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
    @(negedge clk); reg_wr = 1'b0;
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    check("R8 set wins over clear", v, 16'h0001);

    all_off();
    cmd(mk(1, 1, 2, 5));
    ticks(1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    cmd_valid = 1'b1; cmd_word = mk(1, 1, 2, 1);
    @(negedge clk); cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    check("R6 command held during scan", v, 0);
    ticks(1);
    rd(2'd0, v);
    check("R6 command applied after scan", v, 16'h0004);

    all_off();
    cmd(mk(1, 0, 0, 1));
    ticks(1);
    check("R10 no irq with mask clear", irq, 0);
    wr(2'd1, 16'h0001);
    rd(2'd1, v);
    check("R9 mask readback", v, 16'h0001);
    check("R10 no irq with gie clear", irq, 0);
    wr(2'd3, 16'h0003);
    #1 check("R10 irq asserted", irq, 1);
    wr(2'd0, 16'h0001);
    #1 check("R10 irq drops on clear", irq, 0);
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v);
    check("R9 mask full pattern", v, 16'hA5C3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule